// File: doc/BRIEF.md
# Expansion I/O Register Block

This block sits on a 6502-style system bus and answers a handful of memory-mapped addresses in the 0xFC page. It provides a conversion start/result register for an external analog converter, a latched output port whose bits drive the pins of a bit-banged SPI memory card, a status input port, and eight bank-reload request registers. I/O cycles in this page run with a stretched clock high phase, so every register is decoded and written in one system clock with no timing shortcuts.

Requests that need slow work are not serviced here. A conversion start or a bank-reload write is posted to a 32-bit command word that a host processor polls. The host clears the command with an acknowledge strobe and returns conversion results with a result strobe. Writes are one-cycle strobes on `bus_we`; reads are combinational from `bus_addr`.

Top module: `xio_regs`

## Requirements
- R1: After reset the command word is 0, the busy flag is 0, the conversion-done flag is 0, the result register is 0 and the output port is 0.
- R2: A write of 4, 5, 6 or 7 to 0xFC70 while no command is pending posts a conversion command: bit 31 = 1 (pending), bit 30 = 1 (conversion), bits 1:0 = value minus 4 (channel 1..4 as 0..3), all other bits 0; it also clears the done flag.
- R3: A write to 0xFC70 with any value outside 4..7 changes neither the command word, the busy flag nor the done flag.
- R4: A host result strobe loads `host_res` into the result register and sets the done flag one cycle later; a read of 0xFC70 returns the result register. An accepted conversion start in the same cycle wins over the strobe for the done flag.
- R5: A read of 0xFC72 returns bit 7 = `ack_in`, bit 6 = done flag, bit 5 = 1 when `fire_n[1]` is low, bit 4 = 1 when `fire_n[0]` is low, bits 3:0 = 0; a fire input change shows after two clock edges.
- R6: A write to 0xFC71 sets `spi_out` at the next edge; a read of 0xFC71 returns the same byte.
- R7: A write of N to 0xFC04..0xFC07 or 0xFC0C..0xFC0F while no command is pending posts a bank command: bit 31 = 1, bit 30 = 0, bit 29 = 1, bits 11:8 = address bits 3:0 (the bank), bits 7:0 = N (the image), all other bits 0.
- R8: A command write (as in R2 or R7) while bit 31 is set is dropped: bits 30:0 stay unchanged and the busy flag is set.
- R9: `host_ack` clears bit 31 of the command word and the busy flag; if a command is accepted in the same cycle (nothing was pending) the new command stands.
- R10: Any other address, such as 0xFC08 or 0xFC73, has no effect on a write and reads with `bus_hit` = 0 and data 0; `bus_hit` = 1 only at 0xFC70..0xFC72.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_we | input | 1 | One-cycle write strobe |
| bus_rdata | output | 8 | Read data for the current address |
| bus_hit | output | 1 | Address is a readable register of this block |
| ack_in | input | 1 | External acknowledge, also SPI MISO |
| fire_n | input | 2 | Fire buttons, active low, asynchronous |
| spi_out | output | 8 | Latched output port driving the card pins |
| host_res | input | 8 | Conversion result from the host |
| host_res_valid | input | 1 | Result strobe |
| host_ack | input | 1 | Command acknowledge strobe |
| cmd_word | output | 32 | Command mailbox word |
| cmd_busy | output | 1 | A command write was dropped while pending |

## Verification
Register writes, command posting, busy, acknowledge and result strobes all take effect at the first clock edge after the stimulus, so the bench drives at the falling edge and checks one time unit after the next rising edge. Reads are combinational and are checked shortly after the address settles, while fire button inputs are checked only after two rising edges have passed. The random phase keeps a bench-side expectation of every visible register and compares all of them after each cycle.

// File: rtl/xio_regs.sv
module xio_regs #(
  parameter int DW = 8,
  parameter int CW = 32,
  parameter logic [15:0] ADC_ADDR = 16'hFC70,
  parameter logic [15:0] OUT_ADDR = 16'hFC71,
  parameter logic [15:0] IN_ADDR  = 16'hFC72,
  parameter logic [11:0] BANK_PAGE = 12'hFC0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_hit,
  input  logic          ack_in,
  input  logic [1:0]    fire_n,
  output logic [DW-1:0] spi_out,
  input  logic [DW-1:0] host_res,
  input  logic          host_res_valid,
  input  logic          host_ack,
  output logic [CW-1:0] cmd_word,
  output logic          cmd_busy
);
  localparam int PEND = CW - 1;
  localparam int CONV = CW - 2;
  localparam int SWAP = CW - 3;

  logic [DW-1:0] res_q;
  logic          done_q;
  logic [1:0]    f1_q, f2_q;

  wire pending = cmd_word[PEND];
  wire wr_adc  = bus_we && bus_addr == ADC_ADDR;
  wire start   = wr_adc && bus_wdata[DW-1:2] == 1;
  wire wr_bank = bus_we && bus_addr[15:4] == BANK_PAGE && bus_addr[2];
  wire req     = start || wr_bank;
  wire accept  = req && !pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_word <= '0;
      cmd_busy <= 1'b0;
    end else begin
      if (accept) begin
        cmd_word <= '0;
        cmd_word[PEND] <= 1'b1;
        if (wr_bank) begin
          cmd_word[SWAP] <= 1'b1;
          cmd_word[11:8] <= bus_addr[3:0];
          cmd_word[7:0]  <= bus_wdata;
        end else begin
          cmd_word[CONV] <= 1'b1;
          cmd_word[1:0]  <= bus_wdata[1:0];
        end
      end else if (host_ack) begin
        cmd_word[PEND] <= 1'b0;
      end
      if (host_ack) cmd_busy <= 1'b0;
      else if (req && pending) cmd_busy <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= '0;
      done_q  <= 1'b0;
      spi_out <= '0;
      f1_q    <= 2'b11;
      f2_q    <= 2'b11;
    end else begin
      f1_q <= fire_n;
      f2_q <= f1_q;
      if (host_res_valid) res_q <= host_res;
      if (start && !pending) done_q <= 1'b0;
      else if (host_res_valid) done_q <= 1'b1;
      if (bus_we && bus_addr == OUT_ADDR) spi_out <= bus_wdata;
    end
  end

  always_comb begin
    bus_hit = 1'b1;
    case (bus_addr)
      ADC_ADDR: bus_rdata = res_q;
      OUT_ADDR: bus_rdata = spi_out;
      IN_ADDR:  bus_rdata = {ack_in, done_q, ~f2_q[1], ~f2_q[0], 4'b0000};
      default: begin
        bus_rdata = '0;
        bus_hit   = 1'b0;
      end
    endcase
  end

  a_r2_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pending) |=> (!done_q && cmd_word[PEND] && cmd_word[CONV]));
  a_r3_bad_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_adc && !start && !host_ack && !host_res_valid) |=> ($stable(cmd_word) && $stable(done_q)));
  a_r4_result_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    (host_res_valid && !(start && !pending)) |=> (done_q && res_q == $past(host_res)));
  a_r8_held_off: assert property (@(posedge clk) disable iff (!rst_n)
    (req && pending) |=> ($stable(cmd_word[CW-2:0]) && (cmd_busy || $past(host_ack))));
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack && !accept) |=> (!cmd_word[PEND] && !cmd_busy));
  a_r7_swap_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bank && !pending) |=> (cmd_word[SWAP] && !cmd_word[CONV]));
endmodule

// File: tb/test_xio_regs.sv
module test_xio_regs;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [15:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, host_res = 0;
  logic bus_we = 0, ack_in = 0, host_res_valid = 0, host_ack = 0;
  logic [1:0] fire_n = 2'b11;
  logic [7:0] bus_rdata, spi_out;
  logic bus_hit, cmd_busy;
  logic [31:0] cmd_word;

  int total = 0, bad = 0;
  logic [31:0] ex_cmd;
  logic ex_busy, ex_done;
  logic [7:0] ex_res, ex_out;

  xio_regs i_xio_regs (.clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_rdata, .bus_hit,
    .ack_in, .fire_n, .spi_out, .host_res, .host_res_valid, .host_ack, .cmd_word, .cmd_busy);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] conv_cmd(logic [7:0] d);
    return {3'b110, 27'd0, d[1:0]};
  endfunction

  function automatic logic [31:0] bank_cmd(logic [15:0] a, logic [7:0] d);
    return {3'b101, 17'd0, a[3:0], d};
  endfunction

  task automatic model(logic we, logic [15:0] a, logic [7:0] d, logic ack, logic rv, logic [7:0] r);
    logic is_start, is_bank, req, pend;
    is_start = we && a == 16'hFC70 && d >= 4 && d <= 7;
    is_bank  = we && a[15:4] == 12'hFC0 && a[2];
    req = is_start || is_bank;
    pend = ex_cmd[31];
    if (req && !pend) ex_cmd = is_bank ? bank_cmd(a, d) : conv_cmd(d);
    else if (ack) ex_cmd[31] = 1'b0;
    if (ack) ex_busy = 1'b0;
    else if (req && pend) ex_busy = 1'b1;
    if (is_start && !pend) ex_done = 1'b0;
    else if (rv) ex_done = 1'b1;
    if (rv) ex_res = r;
    if (we && a == 16'hFC71) ex_out = d;
  endtask

  task automatic cycle(logic we, logic [15:0] a, logic [7:0] d, logic ack, logic rv, logic [7:0] r);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; host_ack = ack; host_res_valid = rv; host_res = r;
    @(posedge clk);
    #1;
    bus_we = 0; host_ack = 0; host_res_valid = 0;
    model(we, a, d, ack, rv, r);
  endtask

  task automatic rd(logic [15:0] a);
    bus_addr = a;
    #1;
  endtask

  task automatic check_all(string req);
    chk(req, cmd_word, ex_cmd);
    chk(req, {31'd0, cmd_busy}, {31'd0, ex_busy});
    chk(req, {24'd0, spi_out}, {24'd0, ex_out});
    rd(16'hFC70); chk(req, {24'd0, bus_rdata}, {24'd0, ex_res});
    rd(16'hFC72); chk(req, {24'd0, bus_rdata}, {24'd0, ack_in, ex_done, ~fire_n[1], ~fire_n[0], 4'b0});
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] pool [12];
    pool = '{16'hFC70, 16'hFC71, 16'hFC72, 16'hFC04, 16'hFC05, 16'hFC07, 16'hFC0C,
             16'hFC0F, 16'hFC08, 16'hFC73, 16'h8000, 16'hFC70};
    void'($urandom(32'd1234));
    ex_cmd = 0; ex_busy = 0; ex_done = 0; ex_res = 0; ex_out = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    check_all("R1");

    // R2 conversion start, value 6 -> channel index 2
    cycle(1, 16'hFC70, 8'd6, 0, 0, 0);
    chk("R2", cmd_word, 32'hC000_0002);
    // R8 held off while pending
    cycle(1, 16'hFC05, 8'd2, 0, 0, 0);
    chk("R8", cmd_word, 32'hC000_0002);
    chk("R8", {31'd0, cmd_busy}, 32'd1);
    // R9 ack clears pending and busy
    cycle(0, 16'hFC00, 0, 1, 0, 0);
    chk("R9", cmd_word, 32'h4000_0002);
    chk("R9", {31'd0, cmd_busy}, 32'd0);
    // R4 result
    cycle(0, 16'hFC00, 0, 0, 1, 8'hA5);
    rd(16'hFC70); chk("R4", {24'd0, bus_rdata}, 32'hA5);
    rd(16'hFC72); chk("R4", {24'd0, bus_rdata[6]}, 32'd1);
    // R3 out-of-range code ignored
    cycle(1, 16'hFC70, 8'd8, 0, 0, 0);
    chk("R3", cmd_word, 32'h4000_0002);
    rd(16'hFC72); chk("R3", {24'd0, bus_rdata[6]}, 32'd1);
    cycle(1, 16'hFC70, 8'd3, 0, 0, 0);
    chk("R3", cmd_word, 32'h4000_0002);
    // R7 bank request: image 2 into bank 5
    cycle(1, 16'hFC05, 8'd2, 0, 0, 0);
    chk("R7", cmd_word, 32'hA000_0502);
    // R9 ack coincident with new accept: new command stands
    cycle(0, 16'hFC00, 0, 1, 0, 0);
    cycle(1, 16'hFC0E, 8'h17, 1, 0, 0);
    chk("R9", cmd_word, 32'hA000_0E17);
    cycle(0, 16'hFC00, 0, 1, 0, 0);
    // R2 start clears done
    cycle(1, 16'hFC70, 8'd4, 0, 0, 0);
    chk("R2", cmd_word, 32'hC000_0000);
    rd(16'hFC72); chk("R2", {24'd0, bus_rdata[6]}, 32'd0);
    cycle(0, 16'hFC00, 0, 1, 0, 0);
    // R6 output port
    cycle(1, 16'hFC71, 8'h3C, 0, 0, 0);
    chk("R6", {24'd0, spi_out}, 32'h3C);
    rd(16'hFC71); chk("R6", {24'd0, bus_rdata}, 32'h3C);
    // R10 unmapped addresses
    cycle(1, 16'hFC08, 8'd9, 0, 0, 0);
    cycle(1, 16'hFC73, 8'd9, 0, 0, 0);
    chk("R10", cmd_word, ex_cmd);
    rd(16'hFC73); chk("R10", {31'd0, bus_hit}, 32'd0);
    rd(16'hFC08); chk("R10", {24'd0, bus_rdata}, 32'd0);
    rd(16'hFC72); chk("R10", {31'd0, bus_hit}, 32'd1);
    // R5 input port with synchronizer latency
    ack_in = 1;
    @(negedge clk); fire_n = 2'b01;
    @(posedge clk); #1;
    rd(16'hFC72); chk("R5", {24'd0, bus_rdata[5:4]}, 32'd0);
    @(posedge clk); #1;
    rd(16'hFC72); chk("R5", {24'd0, bus_rdata[7], bus_rdata[5:0]}, {24'd0, 1'b1, 2'b10, 4'b0});
    @(negedge clk); fire_n = 2'b10;
    repeat (2) @(posedge clk); #1;
    rd(16'hFC72); chk("R5", {24'd0, bus_rdata[5:4]}, 32'd1);

    // random phase: R2 R3 R4 R6 R7 R8 R9 R10
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [7:0] d;
      a = pool[$urandom_range(0, 11)];
      d = $urandom();
      if (a == 16'hFC70 && $urandom_range(0, 1) == 1) d = 8'($urandom_range(4, 7));
      cycle($urandom_range(0, 3) != 0, a, d, $urandom_range(0, 4) == 0,
            $urandom_range(0, 5) == 0, 8'($urandom()));
      if (i % 37 == 0) begin
        @(negedge clk); ack_in = $urandom(); fire_n = 2'($urandom());
        repeat (2) @(posedge clk); #1;
      end
      check_all("R8");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule